// File: doc/BRIEF.md
# Instruction Sequencer with Return Stack in Data Memory

This block produces the instruction address for a small 4-bit controller core. It keeps a 10-bit program counter that advances by one per completed instruction, can be loaded from a jump target (all ten bits, or only the low eight bits within the current 256-word page), and handles subroutine calls and returns through a return stack. The stack has four slots and uses words at the top of the general data memory. A 2-bit stack pointer selects the slot.

A call stores the address of the next instruction (PC+1) in the current slot. It then advances the stack pointer and loads the target. A return steps the stack pointer back and loads the stored value plus two. Each stored 10-bit address is split across two 5-bit data-memory words. The low half goes to word `0x0F - sp` and the high half to the companion word sixteen places above it. The block keeps its own copy of the slots for returns. It also issues a registered write request so that the shared data memory holds the same image.

A call made while the stack pointer is already at its last value, or a return made while it is at zero, is a fault. It clears the program counter and the stack pointer and raises a one-cycle internal reset request. A stall input freezes the sequencer. An all-clear input, like the reset, returns it to address zero.

Top module: `instr_sequencer`

## Requirements
- R1: After `rst` or `all_clear` at a clock edge (all_clear wins even over `stall`), `pc` = 0, `sp` = 0, `stk_we` = 0 and `fault_rst` = 0.
- R2: With only `step` high, `pc` becomes `pc`+1 at the next edge, wrapping from 0x3FF to 0x000.
- R3: With `jmp_en` high and `jmp_page` low, `pc` takes all 10 bits of `jmp_target`.
- R4: With `jmp_en` and `jmp_page` high, `pc[7:0]` takes `jmp_target[7:0]` and `pc[9:8]` keeps its value.
- R5: A call with `sp` < 3 sets `pc` to `jmp_target` and `sp` to `sp`+1. In the next cycle it shows `stk_we` = 1, `stk_wdata` = old `pc`+1 and `stk_addr` = 0x0F - old `sp`. The mapping is sp 0→0x0F, 1→0x0E, 2→0x0D, 3→0x0C. `stk_wdata[4:0]` is for word `stk_addr` and `stk_wdata[9:5]` is for word `stk_addr`+16.
- R6: A return with `sp` > 0 sets `pc` to the most recently stored return value plus 2, sets `sp` to `sp`-1 and writes nothing. Nested calls return in last-in first-out order.
- R7: A call with `sp` = 3 is an overflow. At the next edge `pc` = 0, `sp` = 0, `fault_rst` = 1 for one cycle, and no write is issued.
- R8: A return with `sp` = 0 is an underflow. At the next edge `pc` = 0, `sp` = 0 and `fault_rst` = 1 for one cycle.
- R9: While `stall` is high and `all_clear` is low, `pc` and `sp` hold, all strobes are ignored and `stk_we` is 0.
- R10: When several strobes are high, the priority is call, then return, then jump, then step. With no strobe, `pc` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| all_clear | input | 1 | Synchronous clear of the sequencer state, overrides stall |
| stall | input | 1 | Freeze program counter and stack pointer |
| step | input | 1 | Instruction completed, advance by one |
| jmp_en | input | 1 | Load the program counter from the jump target |
| jmp_page | input | 1 | With jmp_en: load only the low 8 bits |
| jmp_target | input | 10 | Jump or call target address |
| call_en | input | 1 | Subroutine call strobe |
| ret_en | input | 1 | Subroutine return strobe |
| pc | output | 10 | Program counter |
| sp | output | 2 | Stack pointer |
| stk_we | output | 1 | Stack write request to data memory |
| stk_addr | output | 5 | Data-memory address of the low return-address word |
| stk_wdata | output | 10 | Return address to store, low half at stk_addr, high half at stk_addr+16 |
| fault_rst | output | 1 | One-cycle internal reset request after stack overflow or underflow |

## Verification
A corrupted stack pointer shows up one cycle later. `stk_addr` names the wrong data-memory word on the next call, an early or missing fault appears on `fault_rst`, and `sp` itself is visible at the port. A wrong stored return value stays hidden until its matching return, when `pc` lands away from the saved address plus two. The nested call and return sequence therefore checks every slot in last-in first-out order. Priority or stall errors are visible at the very next edge as a wrong `pc` or a stray `stk_we`.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [2:0] {
    OP_HOLD = 3'd0,
    OP_STEP = 3'd1,
    OP_JUMP = 3'd2,
    OP_PAGE = 3'd3,
    OP_CALL = 3'd4,
    OP_RET  = 3'd5
  } seq_op_e;
endpackage

// File: rtl/seq_op_arbiter.sv
module seq_op_arbiter
  import seq_pkg::*;
(
  input  logic    step,
  input  logic    jmp_en,
  input  logic    jmp_page,
  input  logic    call_en,
  input  logic    ret_en,
  output seq_op_e op
);
  // fixed priority: call, return, jump, step
  always_comb begin
    if (call_en)      op = OP_CALL;
    else if (ret_en)  op = OP_RET;
    else if (jmp_en)  op = jmp_page ? OP_PAGE : OP_JUMP;
    else if (step)    op = OP_STEP;
    else              op = OP_HOLD;
  end
endmodule

// File: rtl/seq_pc_next.sv
module seq_pc_next
  import seq_pkg::*;
#(
  parameter int PC_W   = 10,
  parameter int PAGE_W = 8
) (
  input  seq_op_e         op,
  input  logic [PC_W-1:0] pc_q,
  input  logic [PC_W-1:0] target,
  input  logic [PC_W-1:0] pop_data,
  output logic [PC_W-1:0] pc_d,
  output logic [PC_W-1:0] push_data
);
  localparam logic [PC_W-1:0] ONE = PC_W'(1);
  localparam logic [PC_W-1:0] TWO = PC_W'(2);

  assign push_data = pc_q + ONE;

  always_comb begin
    unique case (op)
      OP_STEP: pc_d = pc_q + ONE;
      OP_JUMP: pc_d = target;
      OP_PAGE: pc_d = {pc_q[PC_W-1:PAGE_W], target[PAGE_W-1:0]};
      OP_CALL: pc_d = target;
      OP_RET:  pc_d = pop_data + TWO;
      default: pc_d = pc_q;
    endcase
  end
endmodule

// File: rtl/seq_sp_ctrl.sv
module seq_sp_ctrl
  import seq_pkg::*;
#(
  parameter int SP_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            advance,
  input  seq_op_e         op,
  output logic [SP_W-1:0] sp_q,
  output logic            fault,
  output logic            push_en,
  output logic [SP_W-1:0] pop_idx
);
  localparam logic [SP_W-1:0] SP_LAST = {SP_W{1'b1}};
  localparam logic [SP_W-1:0] SP_ONE  = SP_W'(1);

  logic overflow, underflow;

  assign overflow  = (op == OP_CALL) && (sp_q == SP_LAST);
  assign underflow = (op == OP_RET)  && (sp_q == '0);
  assign fault     = advance && (overflow || underflow);
  assign push_en   = advance && (op == OP_CALL) && !overflow;
  assign pop_idx   = sp_q - SP_ONE;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sp_q <= '0;
    end else if (advance) begin
      if (overflow || underflow)  sp_q <= '0;
      else if (op == OP_CALL)     sp_q <= sp_q + SP_ONE;
      else if (op == OP_RET)      sp_q <= sp_q - SP_ONE;
    end
  end
endmodule

// File: rtl/seq_ret_store.sv
module seq_ret_store #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 10
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DATA_W-1:0]        rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/instr_sequencer.sv
module instr_sequencer
  import seq_pkg::*;
#(
  parameter int PC_W    = 10,
  parameter int PAGE_W  = 8,
  parameter int SP_W    = 2,
  parameter int DMEM_AW = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               all_clear,
  input  logic               stall,
  input  logic               step,
  input  logic               jmp_en,
  input  logic               jmp_page,
  input  logic [PC_W-1:0]    jmp_target,
  input  logic               call_en,
  input  logic               ret_en,
  output logic [PC_W-1:0]    pc,
  output logic [SP_W-1:0]    sp,
  output logic               stk_we,
  output logic [DMEM_AW-1:0] stk_addr,
  output logic [PC_W-1:0]    stk_wdata,
  output logic               fault_rst
);
  localparam int               DEPTH   = 1 << SP_W;
  localparam logic [DMEM_AW-1:0] LO_TOP = DMEM_AW'((1 << (DMEM_AW-1)) - 1);

  seq_op_e           op;
  logic              advance;
  logic              fault, push_en;
  logic [SP_W-1:0]   pop_idx;
  logic [PC_W-1:0]   pc_d, push_data, pop_data;

  assign advance = !stall;

  seq_op_arbiter u_arb (
    .step(step), .jmp_en(jmp_en), .jmp_page(jmp_page),
    .call_en(call_en), .ret_en(ret_en), .op(op)
  );

  seq_sp_ctrl #(.SP_W(SP_W)) u_sp (
    .clk(clk), .rst(rst), .clear(all_clear), .advance(advance), .op(op),
    .sp_q(sp), .fault(fault), .push_en(push_en), .pop_idx(pop_idx)
  );

  seq_ret_store #(.DEPTH(DEPTH), .DATA_W(PC_W)) u_store (
    .clk(clk), .we(push_en), .waddr(sp), .wdata(push_data),
    .raddr(pop_idx), .rdata(pop_data)
  );

  seq_pc_next #(.PC_W(PC_W), .PAGE_W(PAGE_W)) u_next (
    .op(op), .pc_q(pc), .target(jmp_target), .pop_data(pop_data),
    .pc_d(pc_d), .push_data(push_data)
  );

  always_ff @(posedge clk) begin
    if (rst || all_clear) begin
      pc        <= '0;
      stk_we    <= 1'b0;
      stk_addr  <= '0;
      stk_wdata <= '0;
      fault_rst <= 1'b0;
    end else begin
      stk_we    <= 1'b0;
      fault_rst <= 1'b0;
      if (advance) begin
        if (fault) begin
          pc        <= '0;
          fault_rst <= 1'b1;
        end else begin
          pc <= pc_d;
        end
        if (push_en) begin
          stk_we    <= 1'b1;
          stk_addr  <= LO_TOP - DMEM_AW'(sp);
          stk_wdata <= push_data;
        end
      end
    end
  end
endmodule

// File: rtl/instr_sequencer_chk.sv
module instr_sequencer_chk #(
  parameter int PC_W    = 10,
  parameter int PAGE_W  = 8,
  parameter int SP_W    = 2,
  parameter int DMEM_AW = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               all_clear,
  input logic               stall,
  input logic               step,
  input logic               jmp_en,
  input logic               jmp_page,
  input logic [PC_W-1:0]    jmp_target,
  input logic               call_en,
  input logic               ret_en,
  input logic [PC_W-1:0]    pc,
  input logic [SP_W-1:0]    sp,
  input logic               stk_we,
  input logic [DMEM_AW-1:0] stk_addr,
  input logic [PC_W-1:0]    stk_wdata,
  input logic               fault_rst
);
  logic go;
  assign go = !stall && !all_clear;

  assert_clear_R1: assert property (@(posedge clk) disable iff (rst)
    all_clear |=> (pc == '0 && sp == '0 && !stk_we && !fault_rst));

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (go && step && !jmp_en && !call_en && !ret_en) |=> (pc == $past(pc) + PC_W'(1)));

  assert_jump_R3: assert property (@(posedge clk) disable iff (rst)
    (go && jmp_en && !jmp_page && !call_en && !ret_en) |=> (pc == $past(jmp_target)));

  assert_page_R4: assert property (@(posedge clk) disable iff (rst)
    (go && jmp_en && jmp_page && !call_en && !ret_en) |=>
      (pc[PC_W-1:PAGE_W] == $past(pc[PC_W-1:PAGE_W]) &&
       pc[PAGE_W-1:0] == $past(jmp_target[PAGE_W-1:0])));

  assert_push_R5: assert property (@(posedge clk) disable iff (rst)
    (go && call_en && sp != '1) |=>
      (stk_we && stk_wdata == $past(pc) + PC_W'(1) && sp == $past(sp) + SP_W'(1)
       && pc == $past(jmp_target)));

  assert_pop_R6: assert property (@(posedge clk) disable iff (rst)
    (go && !call_en && ret_en && sp != '0) |=> (sp == $past(sp) - SP_W'(1) && !stk_we));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (go && call_en && sp == '1) |=> (fault_rst && pc == '0 && sp == '0 && !stk_we));

  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
    (go && !call_en && ret_en && sp == '0) |=> (fault_rst && pc == '0 && sp == '0));

  assert_fault_cause_R7: assert property (@(posedge clk) disable iff (rst)
    fault_rst |-> $past(call_en || ret_en));

  assert_stall_R9: assert property (@(posedge clk) disable iff (rst)
    (stall && !all_clear) |=> ($stable(pc) && $stable(sp) && !stk_we && !fault_rst));
endmodule

bind instr_sequencer instr_sequencer_chk #(
  .PC_W(PC_W), .PAGE_W(PAGE_W), .SP_W(SP_W), .DMEM_AW(DMEM_AW)
) u_chk (
  .clk(clk), .rst(rst), .all_clear(all_clear), .stall(stall), .step(step),
  .jmp_en(jmp_en), .jmp_page(jmp_page), .jmp_target(jmp_target),
  .call_en(call_en), .ret_en(ret_en), .pc(pc), .sp(sp), .stk_we(stk_we),
  .stk_addr(stk_addr), .stk_wdata(stk_wdata), .fault_rst(fault_rst)
);

// File: tb/instr_sequencer_test.sv
`timescale 1ns/1ps
module instr_sequencer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       all_clear = 0, stall = 0, step = 0, jmp_en = 0, jmp_page = 0;
  logic       call_en = 0, ret_en = 0;
  logic [9:0] jmp_target = '0;
  logic [9:0] pc, stk_wdata;
  logic [1:0] sp;
  logic       stk_we, fault_rst;
  logic [4:0] stk_addr;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  instr_sequencer uut (
    .clk(clk), .rst(rst), .all_clear(all_clear), .stall(stall), .step(step),
    .jmp_en(jmp_en), .jmp_page(jmp_page), .jmp_target(jmp_target),
    .call_en(call_en), .ret_en(ret_en), .pc(pc), .sp(sp), .stk_we(stk_we),
    .stk_addr(stk_addr), .stk_wdata(stk_wdata), .fault_rst(fault_rst)
  );

  task automatic chk(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  // drive at falling edge, let one rising edge act, sample at next falling edge
  task automatic apply(bit s, bit j, bit pg, logic [9:0] t, bit c, bit r, bit st, bit ac);
    step = s; jmp_en = j; jmp_page = pg; jmp_target = t;
    call_en = c; ret_en = r; stall = st; all_clear = ac;
    @(posedge clk);
    @(negedge clk);
    step = 0; jmp_en = 0; jmp_page = 0; call_en = 0; ret_en = 0; stall = 0; all_clear = 0;
  endtask

  task automatic state(string req, int epc, int esp);
    chk(req, "pc", pc, epc);
    chk(req, "sp", sp, esp);
  endtask

  task automatic push_seen(string req, int eaddr, int edata);
    chk(req, "stk_we", stk_we, 1);
    chk(req, "stk_addr", stk_addr, eaddr);
    chk(req, "stk_wdata", stk_wdata, edata);
  endtask

  task automatic t_reset;
    state("R1", 0, 0);
    chk("R1", "stk_we", stk_we, 0);
    chk("R1", "fault_rst", fault_rst, 0);
  endtask

  task automatic t_step_wrap;
    apply(1,0,0,0,0,0,0,0); state("R2", 1, 0);
    apply(1,0,0,0,0,0,0,0); apply(1,0,0,0,0,0,0,0); state("R2", 3, 0);
    apply(0,1,0,10'h3FE,0,0,0,0); state("R3", 10'h3FE, 0);
    apply(1,0,0,0,0,0,0,0); state("R2", 10'h3FF, 0);
    apply(1,0,0,0,0,0,0,0); state("R2", 0, 0);
  endtask

  task automatic t_page;
    apply(0,1,0,10'h2A5,0,0,0,0); state("R3", 10'h2A5, 0);
    apply(0,1,1,10'h13C,0,0,0,0); state("R4", 10'h23C, 0);
  endtask

  task automatic t_nested;
    apply(0,0,0,10'h100,1,0,0,0); state("R5", 10'h100, 1); push_seen("R5", 5'h0F, 10'h23D);
    apply(0,0,0,10'h080,1,0,0,0); state("R5", 10'h080, 2); push_seen("R5", 5'h0E, 10'h101);
    apply(0,0,0,10'h300,1,0,0,0); state("R5", 10'h300, 3); push_seen("R5", 5'h0D, 10'h081);
    apply(0,0,0,0,0,0,0,0); chk("R5", "stk_we idle", stk_we, 0); state("R10", 10'h300, 3);
    apply(0,0,0,0,0,1,0,0); state("R6", 10'h083, 2); chk("R6", "stk_we", stk_we, 0);
    apply(0,0,0,0,0,1,0,0); state("R6", 10'h103, 1);
    apply(0,0,0,0,0,1,0,0); state("R6", 10'h23F, 0);
  endtask

  task automatic t_underflow;
    apply(0,0,0,0,0,1,0,0); state("R8", 0, 0); chk("R8", "fault_rst", fault_rst, 1);
    apply(0,0,0,0,0,0,0,0); chk("R8", "fault_rst pulse", fault_rst, 0);
  endtask

  task automatic t_overflow;
    apply(0,0,0,10'h010,1,0,0,0);
    apply(0,0,0,10'h020,1,0,0,0);
    apply(0,0,0,10'h030,1,0,0,0); state("R7", 10'h030, 3);
    apply(0,0,0,10'h040,1,0,0,0); state("R7", 0, 0);
    chk("R7", "fault_rst", fault_rst, 1);
    chk("R7", "stk_we", stk_we, 0);
    apply(0,0,0,0,0,0,0,0); chk("R7", "fault_rst pulse", fault_rst, 0);
  endtask

  task automatic t_stall;
    apply(0,1,0,10'h155,0,0,0,0);
    apply(1,0,0,10'h222,1,0,1,0); state("R9", 10'h155, 0); chk("R9", "stk_we", stk_we, 0);
    apply(0,1,0,10'h222,0,1,1,0); state("R9", 10'h155, 0); chk("R9", "fault_rst", fault_rst, 0);
    apply(0,0,0,10'h300,1,0,0,0); state("R5", 10'h300, 1);
    apply(1,0,0,0,0,0,1,1); state("R1", 0, 0);
  endtask

  task automatic t_priority;
    apply(0,1,0,10'h050,0,0,0,0);
    apply(1,1,0,10'h200,1,1,0,0); state("R10", 10'h200, 1); push_seen("R10", 5'h0F, 10'h051);
    apply(1,1,0,10'h111,0,1,0,0); state("R10", 10'h053, 0);
    apply(1,1,0,10'h0AA,0,0,0,0); state("R10", 10'h0AA, 0);
    apply(0,0,0,10'h3C3,0,0,0,0); state("R10", 10'h0AA, 0);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset();
    t_step_wrap();
    t_page();
    t_nested();
    t_underflow();
    t_overflow();
    t_stall();
    t_priority();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule